// File: doc/BRIEF.md
# Parametric Raster Timing and Test Colour Source

This block produces the raster timing and pixel colour that feed a DVI-style transmitter. Two position counters walk through each line and each frame. Every horizontal and vertical interval length is a compile-time parameter, and so is the polarity of each sync. The defaults give 640x480 visible pixels at a 25 MHz pixel clock, which is one pixel per clock.

From the current position the block derives:
- horizontal and vertical sync,
- a data-enable flag that is high over the visible window,
- 8-bit red, green and blue.

The colour comes from one of two sources, selected by a mode input:
- eight vertical colour bars spread across the visible line;
- one constant colour that fills every visible pixel, useful for checking a link.

All outputs leave through one register stage, so sync, enable and colour stay aligned. Colour is zero whenever the enable is low, and that includes every sync interval.

The asynchronous active-low reset is released through a two-flop synchronizer. After release, the counters start at the first visible pixel of the first line.

Top module: `vid_raster_src`

## Requirements
- R1: While `rst_n` is low, `de` is 0, all three colour outputs are 0, and each sync output sits at its inactive level. The active level of a sync is 1 when its `*_SYNC_HIGH` parameter is 1, and 0 otherwise.
- R2: After `rst_n` rises, the outputs keep their reset values for two rising edges. The third rising edge presents pixel (h=0, v=0). Each later edge presents the next pixel. A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks, and a frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines.
- R3: `de` is 1 exactly when h < H_ACTIVE and v < V_ACTIVE.
- R4: `hsync` is at its active level exactly when H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC.
- R5: `vsync` is at its active level for whole lines, exactly when V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC.
- R6: When `de` is 0, `red`, `green` and `blue` are all 0. This covers both sync intervals and both constant-colour and pattern modes.
- R7: With `mode_const` = 0, a visible pixel shows bar index i = floor(h*8/H_ACTIVE). In that bar each channel is either 0xFF or 0x00: red is 0xFF when bit 2 of i is set, green when bit 1 is set, and blue when bit 0 is set.
- R8: With `mode_const` = 1, every visible pixel shows `const_rgb`: red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R9: `mode_const` and `const_rgb` are sampled on the same edge as the pixel position. A change therefore appears on the very pixel that edge presents, together with that pixel's sync and enable.
- R10: Pulling `rst_n` low in mid-frame forces the R1 values at once, without waiting for a clock edge. The next release restarts at pixel (0,0) with the latency given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_const | input | 1 | 1 selects the constant colour; 0 selects the colour bars |
| const_rgb | input | 24 | Constant colour: red in bits 23:16, green in bits 15:8, blue in bits 7:0 |
| hsync | output | 1 | Horizontal sync, polarity set by H_SYNC_HIGH |
| vsync | output | 1 | Vertical sync, polarity set by V_SYNC_HIGH |
| de | output | 1 | High over visible pixels |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The critical overlap is a colour-mode change that lands on the same clock as a blanking boundary. Examples are the last visible pixel of a line, the first edge of a horizontal sync, the frame wrap back to (0,0), and the first line of vertical sync.

The bench steps its behavioural model until the next presented pixel sits exactly on one of these boundaries, then flips `mode_const` and loads a fresh `const_rgb`. At that clock it expects the new colour only if the pixel is visible, and zero if it is not. A further pass toggles the mode on a short fixed period across a whole frame, which scatters the switch over every kind of position.

// File: rtl/vid_pkg.sv
package vid_pkg;

  localparam int unsigned NUM_BARS = 8;
  localparam int unsigned BAR_BITS = $clog2(NUM_BARS);

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t bar_colour(input logic [BAR_BITS-1:0] idx);
    rgb_t c;
    c.r = idx[2] ? 8'hFF : 8'h00;
    c.g = idx[1] ? 8'hFF : 8'h00;
    c.b = idx[0] ? 8'hFF : 8'h00;
    return c;
  endfunction

endpackage

// File: rtl/vid_rst_sync.sv
module vid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vid_axis_cnt.sv
module vid_axis_cnt #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         last
);

  logic [W-1:0] pos_nxt;

  assign last = (pos == W'(TOTAL - 1));

  always_comb begin
    pos_nxt = pos;
    if (step) begin
      if (last) pos_nxt = '0;
      else      pos_nxt = pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pos} < (W+1)'(TOTAL)) else $error("position out of range"); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (pos == '0)) else $error("counter did not wrap"); // R2

endmodule

// File: rtl/vid_axis_decode.sv
module vid_axis_decode #(
  parameter int ACT = 640,
  parameter int FP  = 16,
  parameter int SW  = 96,
  parameter int W   = 10
) (
  input  logic [W-1:0] pos,
  output logic         in_active,
  output logic         in_sync
);

  localparam logic [W:0] ACT_END  = (W+1)'(ACT);
  localparam logic [W:0] SYNC_BEG = (W+1)'(ACT + FP);
  localparam logic [W:0] SYNC_END = (W+1)'(ACT + FP + SW);

  logic [W:0] pos_x;

  always_comb begin
    pos_x     = {1'b0, pos};
    in_active = (pos_x < ACT_END);
    in_sync   = (pos_x >= SYNC_BEG) && (pos_x < SYNC_END);
  end

endmodule

// File: rtl/vid_colour_src.sv
module vid_colour_src
  import vid_pkg::*;
#(
  parameter int HACT = 640,
  parameter int HW   = 10
) (
  input  logic [HW-1:0] h_pos,
  input  logic          de,
  input  logic          mode_const,
  input  rgb_t          const_col,
  output rgb_t          colour
);

  logic [NUM_BARS-2:0]  past_edge;
  logic [BAR_BITS-1:0]  bar_idx;
  rgb_t                 raw;

  for (genvar k = 1; k < NUM_BARS; k++) begin : g_edge
    localparam int EDGE = (k * HACT + NUM_BARS - 1) / NUM_BARS;
    assign past_edge[k-1] = ({1'b0, h_pos} >= (HW+1)'(EDGE));
  end

  always_comb begin
    bar_idx = BAR_BITS'($countones(past_edge));
    raw     = mode_const ? const_col : bar_colour(bar_idx);
    colour  = de ? raw : '0;
  end

endmodule

// File: rtl/vid_out_stage.sv
module vid_out_stage
  import vid_pkg::*;
#(
  parameter bit HS_HIGH = 1'b0,
  parameter bit VS_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_on,
  input  logic vs_on,
  input  logic de_in,
  input  rgb_t col_in,
  output logic hs_q,
  output logic vs_q,
  output logic de_q,
  output rgb_t col_q
);

  logic hs_d;
  logic vs_d;
  logic de_d;
  rgb_t col_d;

  always_comb begin
    hs_d  = hs_on ? HS_HIGH : ~HS_HIGH;
    vs_d  = vs_on ? VS_HIGH : ~VS_HIGH;
    de_d  = de_in;
    col_d = col_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= ~HS_HIGH;
      vs_q  <= ~VS_HIGH;
      de_q  <= 1'b0;
      col_q <= '0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      col_q <= col_d;
    end
  end

  AST_BLANK_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !de_q |-> (col_q == '0)) else $error("colour during blanking"); // R6

  AST_NO_DE_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> (hs_q != HS_HIGH)) else $error("enable during hsync"); // R4

  AST_NO_DE_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> (vs_q != VS_HIGH)) else $error("enable during vsync"); // R5

endmodule

// File: rtl/vid_raster_src.sv
module vid_raster_src
  import vid_pkg::*;
#(
  parameter int H_ACTIVE    = 640,
  parameter int H_FRONT     = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BACK      = 48,
  parameter int V_ACTIVE    = 480,
  parameter int V_FRONT     = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BACK      = 33,
  parameter bit H_SYNC_HIGH = 1'b0,
  parameter bit V_SYNC_HIGH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_const,
  input  logic [23:0] const_rgb,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic          rst_sync_n;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_last;
  logic          v_last;
  logic          h_act;
  logic          v_act;
  logic          h_sync_on;
  logic          v_sync_on;
  logic          de_nxt;
  rgb_t          col_nxt;
  rgb_t          col_out;

  vid_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  vid_axis_cnt #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .step (1'b1),
    .pos  (h_pos),
    .last (h_last)
  );

  vid_axis_cnt #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .step (h_last),
    .pos  (v_pos),
    .last (v_last)
  );

  vid_axis_decode #(.ACT(H_ACTIVE), .FP(H_FRONT), .SW(H_SYNC), .W(HW)) u_hdec (
    .pos      (h_pos),
    .in_active(h_act),
    .in_sync  (h_sync_on)
  );

  vid_axis_decode #(.ACT(V_ACTIVE), .FP(V_FRONT), .SW(V_SYNC), .W(VW)) u_vdec (
    .pos      (v_pos),
    .in_active(v_act),
    .in_sync  (v_sync_on)
  );

  assign de_nxt = h_act & v_act;

  vid_colour_src #(.HACT(H_ACTIVE), .HW(HW)) u_col (
    .h_pos     (h_pos),
    .de        (de_nxt),
    .mode_const(mode_const),
    .const_col (rgb_t'(const_rgb)),
    .colour    (col_nxt)
  );

  vid_out_stage #(.HS_HIGH(H_SYNC_HIGH), .VS_HIGH(V_SYNC_HIGH)) u_out (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hs_on (h_sync_on),
    .vs_on (v_sync_on),
    .de_in (de_nxt),
    .col_in(col_nxt),
    .hs_q  (hsync),
    .vs_q  (vsync),
    .de_q  (de),
    .col_q (col_out)
  );

  assign red   = col_out.r;
  assign green = col_out.g;
  assign blue  = col_out.b;

  AST_V_HOLDS_MID_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !h_last |=> $stable(v_pos)) else $error("line advanced mid-line"); // R2

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_last && v_last) |=> (h_pos == '0 && v_pos == '0)) else $error("frame wrap"); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!de && red == 8'h00 && green == 8'h00 && blue == 8'h00))
    else $error("outputs active in reset"); // R1

endmodule

// File: tb/tb_vid_raster_src.sv
`timescale 1ns/1ps
module tb_vid_raster_src;

  localparam int CLK_PERIOD = 40;
  localparam int HA = 30, HF = 4, HS = 6, HB = 5;
  localparam int VA = 12, VF = 2, VS = 3, VB = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam bit HSP = 1'b1;
  localparam bit VSP = 1'b0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_const = 1'b0;
  logic [23:0] const_rgb = 24'h123456;
  logic        hsync, vsync, de;
  logic [7:0]  red, green, blue;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_raster_src #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .H_SYNC_HIGH(HSP), .V_SYNC_HIGH(VSP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_const(mode_const), .const_rgb(const_rgb),
    .hsync(hsync), .vsync(vsync), .de(de), .red(red), .green(green), .blue(blue)
  );

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit released = 1'b0;
  bit after_mid_reset = 1'b0;
  bit mode_chg = 1'b0;

  bit         e_hs, e_vs, e_de;
  logic [23:0] e_rgb;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at n=%0d: actual=%0h expected=%0h", tag, what, n, act, exp);
    end
  endtask

  function automatic void model();
    int p, h, v, bar;
    if (!released || n < 3) begin
      e_hs = ~HSP; e_vs = ~VSP; e_de = 1'b0; e_rgb = 24'h0;
      return;
    end
    p = n - 3;
    h = p % HT;
    v = (p / HT) % VT;
    e_de = (h < HA) && (v < VA);
    e_hs = (h >= HA + HF && h < HA + HF + HS) ? HSP : ~HSP;
    e_vs = (v >= VA + VF && v < VA + VF + VS) ? VSP : ~VSP;
    if (!e_de) e_rgb = 24'h0;
    else if (mode_const) e_rgb = const_rgb;
    else begin
      bar = (h * 8) / HA;
      e_rgb = {(bar & 4) ? 8'hFF : 8'h00, (bar & 2) ? 8'hFF : 8'h00, (bar & 1) ? 8'hFF : 8'h00};
    end
  endfunction

  task automatic step();
    string t_rgb, t_de;
    @(posedge clk);
    if (released) n++;
    model();
    @(negedge clk);
    if (!released) begin
      t_de = "R1"; t_rgb = "R1";
    end else begin
      if (n <= 3) t_de = "R2";
      else if (after_mid_reset) t_de = "R10";
      else t_de = "R3";
      if (mode_chg) t_rgb = "R9";
      else if (!e_de) t_rgb = "R6";
      else if (mode_const) t_rgb = "R8";
      else t_rgb = "R7";
    end
    chk(released ? "R4" : "R1", "hsync", hsync, e_hs);
    chk(released ? "R5" : "R1", "vsync", vsync, e_vs);
    chk(t_de, "de", de, e_de);
    chk(t_rgb, "rgb", {red, green, blue}, e_rgb);
    mode_chg = 1'b0;
  endtask

  task automatic run_to(input int th, input int tv);
    int p;
    for (int guard = 0; guard < 2 * HT * VT; guard++) begin
      p = n + 1 - 3;
      if (p >= 0 && (p % HT) == th && ((p / HT) % VT) == tv) return;
      step();
    end
  endtask

  task automatic flip_mode();
    mode_const = ~mode_const;
    const_rgb  = const_rgb + 24'h1F3A57;
    mode_chg   = 1'b1;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset values
    for (int i = 0; i < 4; i++) step();
    @(negedge clk);
    rst_n = 1'b1; released = 1'b1; n = 0;
    // R2, R3..R7: one full frame of colour bars
    for (int i = 0; i < HT * VT + 5; i++) step();
    // R9: mode switches on blanking boundaries
    run_to(HA - 1, 1);        flip_mode(); step();
    run_to(HA, 1);            flip_mode(); step();
    run_to(HA + HF, 2);       flip_mode(); step();
    run_to(HA + HF + HS, 2);  flip_mode(); step();
    run_to(0, VA + VF);       flip_mode(); step();
    run_to(0, 0);             flip_mode(); step();
    run_to(5, 3);             flip_mode(); step();
    // R8: constant colour for a frame
    mode_const = 1'b1; const_rgb = 24'hA5C30F; mode_chg = 1'b1;
    for (int i = 0; i < HT * VT; i++) step();
    // R9: periodic toggling across a frame
    for (int i = 0; i < HT * VT; i++) begin
      if (i % 13 == 0) flip_mode();
      step();
    end
    // R10: asynchronous reset mid-frame
    run_to(HA / 2, VA / 2);
    #5 rst_n = 1'b0; released = 1'b0; n = 0;
    #1;
    chk("R10", "de async", de, 0);
    chk("R10", "rgb async", {red, green, blue}, 0);
    for (int i = 0; i < 3; i++) step();
    @(negedge clk);
    rst_n = 1'b1; released = 1'b1; after_mid_reset = 1'b1;
    mode_const = 1'b0;
    for (int i = 0; i < 2 * HT * VT; i++) step();
    finish_run();
  end

endmodule